// File: doc/BRIEF.md
# I2C Bus Event Monitor

This block sits passively on a two-wire I2C bus and turns what it sees into sticky event flags. Both lines are brought into the local clock domain through a two-flop synchronizer. From there the block detects:

- START and repeated START conditions.
- STOP conditions.
- The acknowledge bit of every byte.
- A match between the 7-bit address of the first byte and a programmed own address.
- START or STOP conditions that break into the middle of a byte.

Each STOP is also sorted by the direction of the transfer it closes. A flag set by an event stays set until software clears it by writing a one to its position. An address match also produces a one-cycle wake pulse.

Each flag can be enabled through a mask vector. The single interrupt line is the OR of all enabled flags. Software reads the status vector to find out which event raised the interrupt. The block never drives the bus and holds no data.

Top module: `i2c_evmon`

## Requirements
- R1: After reset, status_o, masked_o, irq_o and wake_o are all zero.
- R2: A START seen while the bus is idle sets status bit 0. A START seen while a transfer is open (after a START and before a STOP) sets status bit 1 (repeated START).
- R3: Every STOP (SDA rising while SCL is high) sets status bit 2.
- R4: On the ninth SCL rising edge of each byte, SDA low sets status bit 5 (ACK) and SDA high sets status bit 6 (NACK).
- R5: When the first byte after a START or repeated START carries, in its upper 7 bits (sent MSB first), a value equal to own_addr_i, status bit 7 is set. In the same cycle wake_o is high for exactly one clock. Any other address sets neither.
- R6: A STOP that closes a transfer whose address byte was completed sets bit 3 when the R/W bit (last bit of the address byte) was 0 (write), or bit 4 when it was 1 (read). A STOP that comes before the address byte completes sets neither bit.
- R7: A START or STOP seen after 2 to 8 SCL rising edges of the current byte sets status bit 8 (bus error). A condition seen after 0 or 1 rising edges does not set it.
- R8: masked_o equals status_o AND irq_mask_i, and irq_o is high exactly when masked_o is nonzero.
- R9: Writing a one to bit k of clr_i for one cycle clears status bit k and leaves the other bits unchanged. If an event for bit k occurs in the same cycle as the clear, the bit stays set.
- R10: irq_mask_i has no effect on status_o: events are recorded whether enabled or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| own_addr_i | input | 7 | Address to match against |
| irq_mask_i | input | 9 | Per-flag interrupt enable |
| clr_i | input | 9 | Write-one-to-clear strobe per flag |
| status_o | output | 9 | Sticky event flags |
| masked_o | output | 9 | Flags that are enabled in the mask |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | One-cycle wake pulse on address match |

## Verification
The hardest case is a clear that lands in the same clock cycle as the event that sets the same bit. The event only exists for one cycle, three edges after the line changes. The bench changes SDA just after a clock edge to make an idle-bus START. It then raises the clear strobe for bit 0 only during the cycle between the second and third edges that follow, and expects the flag to survive. The mid-byte bus error is reached by cutting a byte short after a chosen number of bits. The counts are picked so that both an illegal count and the legitimate single rising edge before a normal STOP or repeated START are exercised.

// File: rtl/i2c_evmon_pkg.sv
package i2c_evmon_pkg;
  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = ADDR_W + 1;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int NEV     = 9;

  // flag positions (software decodes these)
  localparam int EV_START   = 0;
  localparam int EV_RESTART = 1;
  localparam int EV_STOP    = 2;
  localparam int EV_STOP_WR = 3;
  localparam int EV_STOP_RD = 4;
  localparam int EV_ACK     = 5;
  localparam int EV_NACK    = 6;
  localparam int EV_ADDR    = 7;
  localparam int EV_BUSERR  = 8;

  // upper bits of the first byte against the own address
  function automatic logic addr_hit(input logic [BYTE_W-1:0] shreg,
                                    input logic [ADDR_W-1:0] own);
    return shreg[BYTE_W-1:1] == own;
  endfunction

  // a condition is a break-in once at least two rising edges of the byte passed
  function automatic logic mid_byte(input logic [CNT_W-1:0] cnt);
    return (cnt >= CNT_W'(2)) && (cnt <= CNT_W'(BYTE_W));
  endfunction
endpackage

// File: rtl/i2c_evmon_sync.sv
module i2c_evmon_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic s0, s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s0 <= 1'b1;
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s0 <= raw_i[i];
        s1 <= s0;
        s2 <= s1;
      end
    end
    assign cur_o[i]  = s1;
    assign prev_o[i] = s2;
  end
endmodule

// File: rtl/i2c_evmon_track.sv
module i2c_evmon_track
  import i2c_evmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_d,
  input  logic              sda_s,
  input  logic              sda_d,
  input  logic [ADDR_W-1:0] own_addr,
  output logic [NEV-1:0]    ev_o,
  output logic              busy_o
);
  logic              busy_q, first_q, addr_done_q, dir_rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;

  logic start_c, stop_c, rise_c, ninth_c, mid_c;
  assign start_c = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise_c  = scl_s & ~scl_d;
  assign ninth_c = busy_q & rise_c & (cnt_q == CNT_W'(BYTE_W));
  assign mid_c   = busy_q & mid_byte(cnt_q);

  always_comb begin
    ev_o = '0;
    ev_o[EV_START]   = start_c & ~busy_q;
    ev_o[EV_RESTART] = start_c & busy_q;
    ev_o[EV_STOP]    = stop_c;
    ev_o[EV_STOP_WR] = stop_c & busy_q & addr_done_q & ~dir_rd_q;
    ev_o[EV_STOP_RD] = stop_c & busy_q & addr_done_q & dir_rd_q;
    ev_o[EV_ACK]     = ninth_c & ~sda_s;
    ev_o[EV_NACK]    = ninth_c & sda_s;
    ev_o[EV_ADDR]    = ninth_c & first_q & addr_hit(shreg_q, own_addr);
    ev_o[EV_BUSERR]  = (start_c | stop_c) & mid_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      first_q     <= 1'b0;
      addr_done_q <= 1'b0;
      dir_rd_q    <= 1'b0;
      cnt_q       <= '0;
      shreg_q     <= '0;
    end else if (start_c) begin
      busy_q      <= 1'b1;
      first_q     <= 1'b1;
      addr_done_q <= 1'b0;
      cnt_q       <= '0;
    end else if (stop_c) begin
      busy_q      <= 1'b0;
      first_q     <= 1'b0;
      addr_done_q <= 1'b0;
      cnt_q       <= '0;
    end else if (rise_c && busy_q) begin
      if (cnt_q == CNT_W'(BYTE_W)) begin
        cnt_q <= '0;
        if (first_q) begin
          first_q     <= 1'b0;
          addr_done_q <= 1'b1;
          dir_rd_q    <= shreg_q[0];
        end
      end else begin
        shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
        cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/i2c_evmon_flags.sv
module i2c_evmon_flags #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        f_q <= 1'b0;
      else if (ev_i[k])  f_q <= 1'b1;
      else if (clr_i[k]) f_q <= 1'b0;
    end
    assign flag_o[k] = f_q;
  end
endmodule

// File: rtl/i2c_evmon.sv
module i2c_evmon
  import i2c_evmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [NEV-1:0]    irq_mask_i,
  input  logic [NEV-1:0]    clr_i,
  output logic [NEV-1:0]    status_o,
  output logic [NEV-1:0]    masked_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [1:0]     line_cur, line_prev;
  logic [NEV-1:0] ev_w;
  logic           bus_busy_w;
  logic           wake_q;

  i2c_evmon_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
    .cur_o(line_cur), .prev_o(line_prev)
  );

  i2c_evmon_track u_track (
    .clk(clk), .rst_n(rst_n),
    .scl_s(line_cur[1]), .scl_d(line_prev[1]),
    .sda_s(line_cur[0]), .sda_d(line_prev[0]),
    .own_addr(own_addr_i), .ev_o(ev_w), .busy_o(bus_busy_w)
  );

  i2c_evmon_flags #(.N(NEV)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_w), .clr_i(clr_i), .flag_o(status_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= ev_w[EV_ADDR];
  end

  assign masked_o = status_o & irq_mask_i;
  assign irq_o    = |masked_o;
  assign wake_o   = wake_q;
endmodule

// File: rtl/i2c_evmon_chk.sv
module i2c_evmon_chk
  import i2c_evmon_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [NEV-1:0] ev,
  input logic [NEV-1:0] status,
  input logic [NEV-1:0] clr,
  input logic [NEV-1:0] mask,
  input logic           busy,
  input logic           irq,
  input logic           wake
);
  a_r2_start_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_START] |=> status[EV_START]);
  a_r2_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_RESTART] |-> busy);
  a_r3_stop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_STOP] |=> status[EV_STOP]);
  a_r4_ack_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev[EV_ACK] && ev[EV_NACK]));
  a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_ADDR] |=> (wake && status[EV_ADDR]));
  a_r6_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev[EV_STOP_WR], ev[EV_STOP_RD]}));
  a_r6_dir_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[EV_STOP_WR] || ev[EV_STOP_RD]) |-> ev[EV_STOP]);
  a_r7_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_BUSERR] |-> busy);
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) == '0) |-> !irq);
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status & $past(ev)) == $past(ev)));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~ev)) |=> ((status & $past(clr & ~ev)) == '0));
endmodule

bind i2c_evmon i2c_evmon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev(ev_w), .status(status_o), .clr(clr_i),
  .mask(irq_mask_i), .busy(bus_busy_w), .irq(irq_o), .wake(wake_o)
);

// File: tb/i2c_evmon_test.sv
`timescale 1ns/100ps
module i2c_evmon_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic [6:0] own = 7'h2A;
  logic [8:0] mask = '0, clr = '0;
  logic [8:0] status, masked;
  logic       irq, wake;
  int n_chk = 0, n_fail = 0, wake_cnt = 0;

  always #2.5 clk = ~clk;

  i2c_evmon uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .own_addr_i(own),
    .irq_mask_i(mask), .clr_i(clr), .status_o(status), .masked_o(masked),
    .irq_o(irq), .wake_o(wake)
  );

  always @(negedge clk) if (wake) wake_cnt++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lines(input logic s, input logic d);
    scl = s; sda = d;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();   lines(1, 1); lines(1, 0); lines(0, 0); endtask
  task automatic bus_rstart();  lines(0, 1); lines(1, 1); lines(1, 0); lines(0, 0); endtask
  task automatic bus_stop();    lines(0, 0); lines(1, 0); lines(1, 1); endtask
  task automatic bus_bit(input logic b); lines(0, b); lines(1, b); lines(0, b); endtask
  task automatic bus_byte(input logic [7:0] v, input logic ack_high);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(ack_high);
  endtask

  task automatic clear_all();
    @(posedge clk); #1 clr = '1;
    @(posedge clk); #1 clr = '0;
    @(negedge clk);
    wake_cnt = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 masked", masked, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);
  endtask

  task automatic t_write_match();
    clear_all();
    mask = '0;
    bus_start(); bus_byte({7'h2A, 1'b0}, 1'b0); bus_stop();
    @(negedge clk);
    chk("R2 R3 R4 R6 R10 write flags", status, 9'h0AD);
    chk("R5 wake once", wake_cnt, 1);
    chk("R8 irq masked off", irq, 0);
    mask = 9'h004; @(negedge clk);
    chk("R8 masked", masked, 9'h004);
    chk("R8 irq on", irq, 1);
    mask = 9'h100; @(negedge clk);
    chk("R8 irq disabled bit", irq, 0);
    @(posedge clk); #1 clr = 9'h004;
    @(posedge clk); #1 clr = '0;
    @(negedge clk);
    chk("R9 selective clear", status, 9'h0A9);
    mask = '0;
  endtask

  task automatic t_read_nomatch();
    clear_all();
    bus_start(); bus_byte({7'h15, 1'b1}, 1'b1); bus_stop();
    @(negedge clk);
    chk("R4 R5 R6 read flags", status, 9'h055);
    chk("R5 no wake", wake_cnt, 0);
  endtask

  task automatic t_restart();
    clear_all();
    bus_start(); bus_byte({7'h2A, 1'b0}, 1'b0); bus_byte(8'h55, 1'b0);
    bus_rstart(); bus_byte({7'h2A, 1'b1}, 1'b0); bus_byte(8'hC3, 1'b1);
    bus_stop();
    @(negedge clk);
    chk("R2 R6 restart flags", status, 9'h0F7);
    chk("R5 wake twice", wake_cnt, 2);
  endtask

  task automatic t_early_stop();
    clear_all();
    bus_start(); bus_bit(1); bus_bit(0); bus_bit(1);
    bus_stop();
    @(negedge clk);
    chk("R7 R6 stop mid byte", status, 9'h105);
  endtask

  task automatic t_mid_start();
    clear_all();
    bus_start();
    for (int i = 0; i < 5; i++) bus_bit(i[0]);
    bus_rstart(); bus_stop();
    @(negedge clk);
    chk("R7 R2 start mid byte", status, 9'h107);
  endtask

  task automatic t_clear_race();
    clear_all();
    @(posedge clk); #1 sda = 1'b0;
    @(posedge clk);
    @(posedge clk); #1 clr = 9'h001;
    @(posedge clk); #1 clr = '0;
    @(negedge clk);
    chk("R9 event beats clear", status, 9'h001);
    @(posedge clk); #1 clr = 9'h001;
    @(posedge clk); #1 clr = '0;
    @(negedge clk);
    chk("R9 later clear", status, 9'h000);
    lines(0, 0); bus_stop();
    clear_all();
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write_match();
    t_read_nomatch();
    t_restart();
    t_early_stop();
    t_mid_start();
    t_clear_race();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule